// File: doc/BRIEF.md
# DSI Video Byte Packetizer

This block turns a raw parallel RGB888 video stream into the byte stream of a DSI video link and spreads that stream over one, two or four byte lanes. Edges on the vertical and horizontal sync inputs each produce a 4-byte short packet. Each stretch of active video, framed by the data-enable input, becomes a long packet. The long packet has a 4-byte header, the pixel bytes, and a 2-byte payload checksum. A 4-byte end-of-transmission packet can optionally follow every packet in the same burst.

Everything runs on one byte clock. Pixels are offered through a valid strobe while data-enable is high. A burst is the sequence formed by one packet and its optional end-of-transmission packet. A burst always starts on lane 0, and its bytes fill the lanes in round-robin order. The high-speed enable output frames each burst so that a downstream serializer knows when to leave low-power mode.

The sync, data-enable and pixel inputs come from the video source. The virtual channel and word count inputs are sampled when a packet starts.

Top module: `dsi_video_packetizer`

## Requirements
- R1: While reset is held, hs_en is low and every lane byte and lane valid bit is zero.
- R2: Each sync edge sends a short packet made of a data identifier {vc, dt}, then 0x00, then 0x00, then the ECC byte. The dt value is 0x01 for a vertical sync rise, 0x11 for a vertical sync fall, 0x21 for a horizontal sync rise and 0x31 for a horizontal sync fall. The vc value is vc_in as sampled on the clock edge that detects the event.
- R3: The fourth header byte is the 6-bit Hamming ECC of the 24-bit word {byte2, byte1, data identifier}, computed by the DSI header rule, where bit 0 is bit 0 of the data identifier. Bits 7:6 of that byte are zero.
- R4: A rising edge of de sends a long-packet header made of {vc, DT_LONG} (default 0x3E), then the word count low byte, then the word count high byte, then the ECC byte. The vc and word count values are sampled on the edge that detects the rise. Changes to vc_in and wc_in after that edge have no effect on the packet.
- R5: A pixel is accepted on each clock where de and pix_valid are both high. Each accepted pixel adds three payload bytes in this order: pix_data[7:0], pix_data[15:8], pix_data[23:16].
- R6: With CRC_EN=1, two checksum bytes follow the last payload byte once de is low, low byte first. The checksum is CRC-16 with polynomial x^16+x^12+x^5+1, seeded with 0xFFFF, taking each byte LSB first.
- R7: With CRC_EN=0, the two checksum bytes are 0xFF and 0xFF.
- R8: With EOTP_EN=1, every packet is followed at once, in the same burst, by the bytes 0x08, 0x0F, 0x0F, 0x01.
- R9: Byte n of a burst appears on lane n mod LANES. In any cycle, only lanes 0 to k-1 are valid. Lanes that are not valid carry 0x00, and a partly filled cycle happens only when a burst ends.
- R10: hs_en is high in every cycle where any lane is valid. It stays high without a break from the first byte of a burst to its last byte, and it is low once the burst has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync level |
| hsync | input | 1 | Horizontal sync level |
| de | input | 1 | Active-video data enable |
| pix_valid | input | 1 | Pixel strobe, qualified by de |
| pix_data | input | 24 | Pixel {R, G, B} |
| vc_in | input | 2 | Virtual channel for the next packet |
| wc_in | input | 16 | Word count for the next long packet |
| lane_byte | output | 8*LANES | Byte per lane, lane i in bits [8i+7:8i] |
| lane_valid | output | LANES | Per-lane byte valid |
| hs_en | output | 1 | High-speed burst window |

## Verification
The in-design assertions assume the following about the inputs:
- Only one sync or data-enable edge occurs at a time.
- Such an edge arrives only while the packetizer is idle.
- No pixel is offered during the header cycles that follow a data-enable rise.
- The pixel rate stays at or below LANES/3 pixels per clock, so the internal byte queue cannot overflow.

The directed stimulus drives one event at a time and then waits forty idle cycles. It starts pixels two cycles after data enable rises and offers a pixel only every third cycle. This keeps all three lane configurations, built side by side from the same inputs, within those limits.

// File: rtl/dsi_pkt_pkg.sv
`timescale 1ns/1ps
package dsi_pkt_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_EOT, ST_DRAIN} pk_state_t;

  localparam logic [5:0] DT_VS_START = 6'h01;
  localparam logic [5:0] DT_VS_END   = 6'h11;
  localparam logic [5:0] DT_HS_START = 6'h21;
  localparam logic [5:0] DT_HS_END   = 6'h31;
  localparam logic [23:0] EOT_WORD   = 24'h0F0F08;

  // Header ECC: six parity bits over the 24-bit header word.
  function automatic logic [7:0] hdr_ecc(input logic [23:0] d);
    logic [7:0] e;
    e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    e[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    e[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    e[7:6] = 2'b00;
    return e;
  endfunction

  // Reflected CRC-16 (x^16+x^12+x^5+1), one byte, LSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsi_sync_events.sv
`timescale 1ns/1ps
module dsi_sync_events
  import dsi_pkt_pkg::*;
#(
  parameter logic [5:0] DT_LONG = 6'h3E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vsync,
  input  logic       hsync,
  input  logic       de,
  output logic       evt,
  output logic [5:0] evt_dt,
  output logic       evt_long
);
  logic vs_r, hs_r, de_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_r <= 1'b0;
      hs_r <= 1'b0;
      de_r <= 1'b0;
    end else begin
      vs_r <= vsync;
      hs_r <= hsync;
      de_r <= de;
    end
  end

  // Fixed priority when several edges coincide.
  always_comb begin
    evt      = 1'b1;
    evt_long = 1'b0;
    evt_dt   = 6'h00;
    if (vsync && !vs_r)       evt_dt = DT_VS_START;
    else if (!vsync && vs_r)  evt_dt = DT_VS_END;
    else if (hsync && !hs_r)  evt_dt = DT_HS_START;
    else if (!hsync && hs_r)  evt_dt = DT_HS_END;
    else if (de && !de_r) begin
      evt_dt   = DT_LONG;
      evt_long = 1'b1;
    end else evt = 1'b0;
  end
endmodule

// File: rtl/dsi_crc_acc.sv
`timescale 1ns/1ps
module dsi_crc_acc
  import dsi_pkt_pkg::*;
#(
  parameter int CRC_EN = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        upd,
  input  logic [23:0] pix,
  output logic [15:0] crc
);
  generate
    if (CRC_EN != 0) begin : g_crc
      logic [15:0] acc;
      always_ff @(posedge clk) begin
        if (rst || clear) acc <= 16'hFFFF;
        else if (upd)     acc <= crc16_byte(crc16_byte(crc16_byte(acc, pix[7:0]), pix[15:8]), pix[23:16]);
      end
      assign crc = acc;
    end else begin : g_fixed
      logic unused_in;
      assign unused_in = ^{clk, rst, clear, upd, pix};
      assign crc = 16'hFFFF;
    end
  endgenerate
endmodule

// File: rtl/dsi_lane_buf.sv
`timescale 1ns/1ps
module dsi_lane_buf #(
  parameter int LANES = 2,
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         push_n,
  input  logic [31:0]        push_b,
  input  logic               flush,
  output logic [LVL_W-1:0]   level,
  output logic               pop_any,
  output logic [LANES*8-1:0] lane_byte,
  output logic [LANES-1:0]   lane_valid
);
  logic [7:0]       mem [DEPTH];
  logic [7:0]       nxt [DEPTH];
  logic [LVL_W-1:0] nxt_level;
  int               pop_cnt;

  always_comb begin
    int base;
    pop_cnt = 0;
    if (int'(level) >= LANES) pop_cnt = LANES;
    else if (flush)           pop_cnt = int'(level);
    for (int i = 0; i < DEPTH; i++)
      nxt[i] = (i + pop_cnt < DEPTH) ? mem[i + pop_cnt] : 8'h00;
    base = int'(level) - pop_cnt;
    for (int j = 0; j < 4; j++)
      if (j < int'(push_n) && base + j < DEPTH) nxt[base + j] = push_b[j*8 +: 8];
    nxt_level = LVL_W'(base + int'(push_n));
  end

  assign pop_any = (pop_cnt != 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level      <= '0;
      lane_byte  <= '0;
      lane_valid <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      level <= nxt_level;
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
      for (int i = 0; i < LANES; i++) begin
        lane_valid[i]       <= (i < pop_cnt);
        lane_byte[i*8 +: 8] <= (i < pop_cnt) ? mem[i] : 8'h00;
      end
    end
  end

  assert_buf_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    int'(level) + int'(push_n) - pop_cnt <= DEPTH);

  assert_lane_fill_order_R9: assert property (@(posedge clk) disable iff (rst)
    ((lane_valid + 1'b1) & lane_valid) == '0);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_pad_chk
      assert_pad_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !lane_valid[g] |-> lane_byte[g*8 +: 8] == 8'h00);
    end
  endgenerate
endmodule

// File: rtl/dsi_video_packetizer.sv
`timescale 1ns/1ps
module dsi_video_packetizer
  import dsi_pkt_pkg::*;
#(
  parameter int         LANES   = 2,
  parameter int         DEPTH   = 16,
  parameter logic [5:0] DT_LONG = 6'h3E,
  parameter int         CRC_EN  = 1,
  parameter int         EOTP_EN = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vsync,
  input  logic               hsync,
  input  logic               de,
  input  logic               pix_valid,
  input  logic [23:0]        pix_data,
  input  logic [1:0]         vc_in,
  input  logic [15:0]        wc_in,
  output logic [LANES*8-1:0] lane_byte,
  output logic [LANES-1:0]   lane_valid,
  output logic               hs_en
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  pk_state_t        state, nstate;
  logic             evt, evt_long, long_q;
  logic [5:0]       evt_dt, dt_q;
  logic [1:0]       vc_q;
  logic [15:0]      wc_q, crc;
  logic [2:0]       push_n;
  logic [31:0]      push_b;
  logic             flush, crc_clr, crc_upd, pop_any;
  logic [LVL_W-1:0] level;
  logic [23:0]      hdr_word;

  dsi_sync_events #(.DT_LONG(DT_LONG)) u_evt (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .de(de),
    .evt(evt), .evt_dt(evt_dt), .evt_long(evt_long));

  dsi_crc_acc #(.CRC_EN(CRC_EN)) u_crc (
    .clk(clk), .rst(rst), .clear(crc_clr), .upd(crc_upd), .pix(pix_data), .crc(crc));

  dsi_lane_buf #(.LANES(LANES), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push_n(push_n), .push_b(push_b), .flush(flush),
    .level(level), .pop_any(pop_any), .lane_byte(lane_byte), .lane_valid(lane_valid));

  assign hdr_word = long_q ? {wc_q, vc_q, dt_q} : {16'h0000, vc_q, dt_q};

  always_comb begin
    nstate  = state;
    push_n  = 3'd0;
    push_b  = 32'h0;
    flush   = 1'b0;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    case (state)
      ST_IDLE: if (evt) nstate = ST_HDR;
      ST_HDR: begin
        push_n  = 3'd4;
        push_b  = {hdr_ecc(hdr_word), hdr_word};
        crc_clr = 1'b1;
        if (long_q)            nstate = ST_PAY;
        else if (EOTP_EN != 0) nstate = ST_EOT;
        else                   nstate = ST_DRAIN;
      end
      ST_PAY: begin
        if (!de) begin
          push_n = 3'd2;
          push_b = {16'h0000, crc};
          nstate = (EOTP_EN != 0) ? ST_EOT : ST_DRAIN;
        end else if (pix_valid) begin
          push_n  = 3'd3;
          push_b  = {8'h00, pix_data};
          crc_upd = 1'b1;
        end
      end
      ST_EOT: begin
        push_n = 3'd4;
        push_b = {hdr_ecc(EOT_WORD), EOT_WORD};
        nstate = ST_DRAIN;
      end
      default: begin
        flush = 1'b1;
        if (int'(level) <= LANES) nstate = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      vc_q   <= 2'b00;
      wc_q   <= 16'h0000;
      dt_q   <= 6'h00;
      long_q <= 1'b0;
      hs_en  <= 1'b0;
    end else begin
      state <= nstate;
      if (state == ST_IDLE && evt) begin
        vc_q   <= vc_in;
        wc_q   <= wc_in;
        dt_q   <= evt_dt;
        long_q <= evt_long;
      end
      if (pop_any)                hs_en <= 1'b1;
      else if (state == ST_IDLE)  hs_en <= 1'b0;
    end
  end

  assert_event_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    evt |-> state == ST_IDLE);

  assert_pixel_in_payload_R5: assert property (@(posedge clk) disable iff (rst)
    (de && pix_valid) |-> state == ST_PAY);

  assert_idle_queue_empty_R9: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> level == '0);

  assert_hs_covers_bytes_R10: assert property (@(posedge clk) disable iff (rst)
    (|lane_valid) |-> hs_en);

  assert_eot_follows_packet_R8: assert property (@(posedge clk) disable iff (rst)
    state == ST_EOT |-> ($past(state) == ST_HDR || $past(state) == ST_PAY));
endmodule

// File: tb/tb_dsi_video_packetizer.sv
`timescale 1ns/1ps
module tb_dsi_video_packetizer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        vsync = 0, hsync = 0, de = 0, pix_valid = 0;
  logic [23:0] pix = '0;
  logic [1:0]  vc_in = '0;
  logic [15:0] wc_in = '0;

  logic [15:0] lb0; logic [1:0] lv0; logic hs0;
  logic [7:0]  lb1; logic [0:0] lv1; logic hs1;
  logic [31:0] lb2; logic [3:0] lv2; logic hs2;

  dsi_video_packetizer #(.LANES(2), .CRC_EN(1), .EOTP_EN(1)) dut (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .de(de), .pix_valid(pix_valid),
    .pix_data(pix), .vc_in(vc_in), .wc_in(wc_in), .lane_byte(lb0), .lane_valid(lv0), .hs_en(hs0));
  dsi_video_packetizer #(.LANES(1), .CRC_EN(0), .EOTP_EN(0)) dut_l1 (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .de(de), .pix_valid(pix_valid),
    .pix_data(pix), .vc_in(vc_in), .wc_in(wc_in), .lane_byte(lb1), .lane_valid(lv1), .hs_en(hs1));
  dsi_video_packetizer #(.LANES(4), .CRC_EN(1), .EOTP_EN(0)) dut_l4 (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .de(de), .pix_valid(pix_valid),
    .pix_data(pix), .vc_in(vc_in), .wc_in(wc_in), .lane_byte(lb2), .lane_valid(lv2), .hs_en(hs2));

  int cfg_l[3]   = '{2, 1, 4};
  int cfg_crc[3] = '{1, 0, 1};
  int cfg_eot[3] = '{1, 0, 0};

  logic [7:0]  got   [3][128];
  logic [7:0]  exp_b [3][128];
  int          gn[3], en[3], hs_rise[3];
  logic        hs_prev[3];
  logic [23:0] px[4];
  int          checks = 0, errors = 0;

  function automatic logic [7:0] t_ecc(logic [23:0] d);
    logic [23:0] m[6];
    logic [7:0] e;
    m = '{24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
    e = 8'h00;
    for (int i = 0; i < 6; i++) e[i] = ^(d & m[i]);
    return e;
  endfunction

  function automatic logic [15:0] t_crc(logic [15:0] c, logic [7:0] b);
    logic [7:0] x;
    x = c[7:0] ^ b;
    x = x ^ {x[3:0], 4'b0000};
    return {8'h00, c[15:8]} ^ {x, 8'h00} ^ {5'b00000, x, 3'b000} ^ {12'h000, x[7:4]};
  endfunction

  task automatic fail_line(string msg);
    errors++;
    $display("FAIL %s", msg);
  endtask

  task automatic collect(int k, logic [31:0] lb, logic [3:0] lv, logic hs, int L);
    for (int i = 0; i < L; i++) begin
      if (lv[i]) begin
        if (gn[k] < 128) got[k][gn[k]] = lb[i*8 +: 8];
        gn[k]++;
      end else if (lb[i*8 +: 8] != 8'h00) begin
        checks++;
        fail_line($sformatf("R9 inst%0d pad lane %0d: actual %02h expected 00", k, i, lb[i*8 +: 8]));
      end
      if (i > 0 && lv[i] && !lv[i-1]) begin
        checks++;
        fail_line($sformatf("R9 inst%0d lane fill: actual valid %b expected lanes from 0", k, lv));
      end
    end
    if ((|lv) && !hs) begin
      checks++;
      fail_line($sformatf("R10 inst%0d hs_en: actual 0 expected 1 with valid %b", k, lv));
    end
    if (hs && !hs_prev[k]) hs_rise[k]++;
    hs_prev[k] = hs;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      collect(0, {16'h0, lb0}, {2'b0, lv0}, hs0, 2);
      collect(1, {24'h0, lb1}, {3'b0, lv1}, hs1, 1);
      collect(2, lb2, lv2, hs2, 4);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 3; k++) begin
      gn[k] = 0; en[k] = 0; hs_rise[k] = 0;
    end
  endtask

  task automatic app(int k, logic [7:0] b);
    exp_b[k][en[k]] = b;
    en[k]++;
  endtask

  task automatic exp_eot(int k);
    if (cfg_eot[k] != 0) begin
      app(k, 8'h08); app(k, 8'h0F); app(k, 8'h0F); app(k, t_ecc(24'h0F0F08));
    end
  endtask

  task automatic exp_short(logic [5:0] dt, logic [1:0] vc);
    for (int k = 0; k < 3; k++) begin
      app(k, {vc, dt}); app(k, 8'h00); app(k, 8'h00); app(k, t_ecc({16'h0000, vc, dt}));
      exp_eot(k);
    end
  endtask

  task automatic exp_long(logic [1:0] vc, logic [15:0] wc, int n);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] c;
      app(k, {vc, 6'h3E}); app(k, wc[7:0]); app(k, wc[15:8]); app(k, t_ecc({wc, vc, 6'h3E}));
      c = 16'hFFFF;
      for (int p = 0; p < n; p++)
        for (int b = 0; b < 3; b++) begin
          app(k, px[p][b*8 +: 8]);
          c = t_crc(c, px[p][b*8 +: 8]);
        end
      if (cfg_crc[k] != 0) begin app(k, c[7:0]); app(k, c[15:8]); end
      else begin app(k, 8'hFF); app(k, 8'hFF); end
      exp_eot(k);
    end
  endtask

  task automatic check_stream(string tag, int bursts);
    for (int k = 0; k < 3; k++) begin
      int mism;
      mism = -1;
      for (int i = 0; i < en[k] && i < gn[k] && i < 128; i++)
        if (mism < 0 && got[k][i] != exp_b[k][i]) mism = i;
      checks++;
      if (gn[k] != en[k])
        fail_line($sformatf("%s inst%0d length: actual %0d expected %0d", tag, k, gn[k], en[k]));
      else if (mism >= 0)
        fail_line($sformatf("%s inst%0d byte %0d: actual %02h expected %02h",
                            tag, k, mism, got[k][mism], exp_b[k][mism]));
      checks++;
      if (hs_rise[k] != bursts)
        fail_line($sformatf("R10 inst%0d bursts: actual %0d expected %0d", k, hs_rise[k], bursts));
    end
    checks++;
    if ({hs0, hs1, hs2} != 3'b000)
      fail_line($sformatf("R10 hs_en after burst: actual %b expected 000", {hs0, hs1, hs2}));
    clear_all();
  endtask

  task automatic test_reset_R1();
    checks++;
    if (lv0 != 0 || lv1 != 0 || lv2 != 0)
      fail_line($sformatf("R1 lane valid: actual %b %b %b expected 0", lv0, lv1, lv2));
    checks++;
    if (hs0 || hs1 || hs2)
      fail_line($sformatf("R1 hs_en: actual %b expected 000", {hs0, hs1, hs2}));
    checks++;
    if (lb0 != 0 || lb1 != 0 || lb2 != 0)
      fail_line($sformatf("R1 lane bytes: actual %h %h %h expected 0", lb0, lb1, lb2));
  endtask

  task automatic test_vsync_start_R2();
    clear_all();
    vc_in = 2'd1; vsync = 1'b1;
    tick(40);
    exp_short(6'h01, 2'd1);
    check_stream("R2 R3 R8 vsync start", 1);
  endtask

  task automatic test_sync_ends_R2();
    clear_all();
    vc_in = 2'd2; vsync = 1'b0; tick(40); exp_short(6'h11, 2'd2);
    vc_in = 2'd3; hsync = 1'b1; tick(40); exp_short(6'h21, 2'd3);
    vc_in = 2'd0; hsync = 1'b0; tick(40); exp_short(6'h31, 2'd0);
    check_stream("R2 R3 sync edges", 3);
  endtask

  task automatic drive_line(logic [1:0] vc, logic [15:0] wc, int n);
    clear_all();
    vc_in = vc; wc_in = wc; de = 1'b1;
    tick(1);
    vc_in = ~vc; wc_in = 16'hBEEF;
    tick(1);
    for (int p = 0; p < n; p++) begin
      pix = px[p]; pix_valid = 1'b1;
      tick(1);
      pix_valid = 1'b0;
      tick(2);
    end
    de = 1'b0;
    tick(40);
    exp_long(vc, wc, n);
  endtask

  task automatic test_line_four_R4();
    drive_line(2'd0, 16'd12, 4);
    check_stream("R4 R5 R6 R7 R8 R9 four-pixel line", 1);
  endtask

  task automatic test_line_pad_R9();
    drive_line(2'd2, 16'd3, 1);
    check_stream("R9 R6 R7 one-pixel line with padding", 1);
  endtask

  task automatic test_line_two_R5();
    drive_line(2'd1, 16'd6, 2);
    check_stream("R5 R4 R10 two-pixel line", 1);
  endtask

  initial begin
    #1000000;
    checks++;
    fail_line("watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    px[0] = 24'h123456; px[1] = 24'hABCDEF; px[2] = 24'h0F1E2D; px[3] = 24'hC3A55A;
    for (int k = 0; k < 3; k++) hs_prev[k] = 1'b0;
    clear_all();
    tick(4);
    test_reset_R1();
    rst = 1'b0;
    tick(5);
    test_vsync_start_R2();
    test_sync_ends_R2();
    test_line_four_R4();
    test_line_pad_R9();
    test_line_two_R5();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule